// File: doc/BRIEF.md
# Framed Serial Master with Clock-High Idle

This block is a serial master for the core side of a chip. Words are pushed into a small transmit queue through a valid/ready handshake. Whenever the block is enabled and that queue is not empty, the block opens a frame by pulling an active-low frame-select line low. It then clocks the word out on a transmit line, most significant bit first, and at the same time shifts in a word from the receive line. Each received word goes into a receive queue, and the core pops it from there.

The serial clock rests high. The transmit line changes on falling clock edges. The receive line is sampled on rising edges. The first falling edge comes half a serial period after frame-select drops. When the transmit queue still holds a word at the last capture of the current word, the next word follows without a break and frame-select stays low. Otherwise frame-select returns high one full serial period after the last capture.

The serial period is set by a divider input, and the word length by a 4-bit field. A mode input enables the clock output driver.

Top module: `spi_frame_master`

## Requirements
- R1: While no frame is open (after reset and between frames), the serial clock is 1, frame-select is 1, the transmit line is 0 and busy is 0.
- R2: A frame opens only when enable is 1 and the transmit queue holds a word. With enable at 0, a queued word stays unsent and all lines keep their idle levels.
- R3: The first falling clock edge, carrying the first bit on the transmit line, comes H system clocks after frame-select falls. H is half the serial period.
- R4: The serial period is 2*H system clocks, where H = floor(clk_div/2), and a clk_div of 0 or 1 is treated as H = 1. The transmit line changes only at falling clock edges, and the receive line is captured at rising edges.
- R5: A word_len field L selects L+1 bits for L of 3 or more, and 4 bits for L below 3. The low L+1 bits of the pushed word are sent MSB first. The received bits are placed right-aligned in rx_data, with the upper bits at 0.
- R6: After the last word of a frame, frame-select rises 2*H system clocks after the final rising clock edge.
- R7: If a word is queued at the final capture of the current word, frame-select stays low. The next word's first falling edge comes H system clocks after that capture, so the clock keeps its regular period across the word boundary.
- R8: busy is 1 exactly while frame-select is 0.
- R9: Each received word is written into the receive queue just after its final capture. Words are popped in arrival order, and rx_valid is 1 whenever the queue is not empty.
- R10: A word received while the receive queue is full is discarded and sets overrun. overrun then stays 1 until reset.
- R11: tx_ready is 0 when the transmit queue is full, and a push made while tx_ready is 0 is ignored.
- R12: sclk_oe equals master_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows frames to start and continue |
| master_mode | input | 1 | Enables the clock output driver |
| word_len | input | LEN_W (4) | Word length field, giving the bit count as described in R5 |
| clk_div | input | DIV_W (8) | Serial period in system clocks; the LSB is ignored |
| tx_data | input | DATA_W (16) | Word to be sent |
| tx_valid | input | 1 | Push request into the transmit queue |
| tx_ready | output | 1 | Transmit queue can accept a word |
| rx_data | output | DATA_W (16) | Oldest received word |
| rx_valid | output | 1 | Receive queue not empty |
| rx_pop | input | 1 | Removes the oldest received word |
| sclk | output | 1 | Serial clock, idles high |
| sclk_oe | output | 1 | Output enable for the serial clock driver |
| fss_n | output | 1 | Frame-select, active low |
| mosi | output | 1 | Serial transmit line |
| miso | input | 1 | Serial receive line |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky flag: a received word was lost |

## Verification
The assertions assume that clk_div and word_len change only while busy is 0, because the half-period count is read live. They also assume that miso is always at a known level when it is sampled. The stimulus changes both configuration inputs only between frames. It drives miso from the transmit line through an optional inverter, so every captured bit is defined and predictable. The sweep covers every word_len code, including the codes that clamp to 4 bits, at divider values that give H = 1, 1, 2 and 3.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_RUN   = 2'd2,
        PH_TRAIL = 2'd3
    } phase_e;

    localparam int MIN_WORD_BITS = 4;

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_s;

    fifo_s q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[q.rp];

    always_comb begin
        d = q;
        if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
        if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
        if (do_push && !do_pop)      d.cnt = q.cnt + CW'(1);
        else if (do_pop && !do_push) d.cnt = q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
    import spi_fm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              tx_has,
    input  logic [DATA_W-1:0] tx_word,
    output logic              tx_pop,
    input  logic              miso,
    output logic              sclk,
    output logic              fss_n,
    output logic              mosi,
    output logic              busy,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        phase_e            ph;
        logic [DIV_W-1:0]  cnt;
        logic [CNT_W-1:0]  nbits;
        logic [CNT_W-1:0]  idx;
        logic [DATA_W-1:0] tsh;
        logic [DATA_W-1:0] rsh;
        logic              sclk;
        logic              fss_n;
        logic              mosi;
        logic              push;
        logic [DATA_W-1:0] rword;
    } eng_s;

    eng_s q, d;

    logic [DIV_W-1:0]  half;
    logic [CNT_W-1:0]  len_bits;
    logic [DATA_W-1:0] tx_aligned;
    logic [DATA_W-1:0] rx_shifted;
    logic [DATA_W-1:0] rx_mask;
    logic              last_bit;
    logic              go_on;

    // half serial period in system clocks, never below one
    always_comb begin
        half = clk_div >> 1;
        if (half == '0) half = DIV_W'(1);
    end

    // word length decode with clamping
    always_comb begin
        if (int'(word_len) < MIN_WORD_BITS - 1) len_bits = CNT_W'(MIN_WORD_BITS);
        else if (int'(word_len) + 1 > DATA_W)   len_bits = CNT_W'(DATA_W);
        else                                    len_bits = CNT_W'(word_len) + CNT_W'(1);
    end

    assign tx_aligned = tx_word << (DATA_W - int'(len_bits));
    assign rx_shifted = {q.rsh[DATA_W-2:0], miso};
    assign rx_mask    = {DATA_W{1'b1}} >> (DATA_W - int'(q.nbits));
    assign last_bit   = ((q.idx + CNT_W'(1)) == q.nbits);
    assign go_on      = enable && tx_has;

    always_comb begin
        d      = q;
        d.push = 1'b0;
        tx_pop = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (go_on) begin
                    tx_pop  = 1'b1;
                    d.ph    = PH_LEAD;
                    d.fss_n = 1'b0;
                    d.cnt   = half - DIV_W'(1);
                    d.nbits = len_bits;
                    d.idx   = '0;
                    d.tsh   = tx_aligned;
                end
            end
            PH_LEAD: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - DIV_W'(1);
                end else begin
                    d.sclk = 1'b0;
                    d.mosi = q.tsh[DATA_W-1];
                    d.tsh  = q.tsh << 1;
                    d.cnt  = half - DIV_W'(1);
                    d.ph   = PH_RUN;
                end
            end
            PH_RUN: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - DIV_W'(1);
                end else begin
                    d.cnt = half - DIV_W'(1);
                    if (!q.sclk) begin
                        // rising edge: capture
                        d.sclk = 1'b1;
                        d.rsh  = rx_shifted;
                        if (last_bit) begin
                            d.push  = 1'b1;
                            d.rword = rx_shifted & rx_mask;
                            if (go_on) begin
                                tx_pop  = 1'b1;
                                d.nbits = len_bits;
                                d.idx   = '0;
                                d.tsh   = tx_aligned;
                            end else begin
                                d.ph  = PH_TRAIL;
                                d.cnt = (half << 1) - DIV_W'(1);
                            end
                        end else begin
                            d.idx = q.idx + CNT_W'(1);
                        end
                    end else begin
                        // falling edge: launch next bit
                        d.sclk = 1'b0;
                        d.mosi = q.tsh[DATA_W-1];
                        d.tsh  = q.tsh << 1;
                    end
                end
            end
            PH_TRAIL: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - DIV_W'(1);
                end else begin
                    d.ph    = PH_IDLE;
                    d.fss_n = 1'b1;
                    d.mosi  = 1'b0;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_IDLE;
            q.sclk  <= 1'b1;
            q.fss_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk    = q.sclk;
    assign fss_n   = q.fss_n;
    assign mosi    = q.mosi;
    assign busy    = (q.ph != PH_IDLE);
    assign rx_push = q.push;
    assign rx_word = q.rword;

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
    parameter int DATA_W     = 16,
    parameter int DIV_W      = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int LEN_W      = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              master_mode,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_pop,
    output logic              sclk,
    output logic              sclk_oe,
    output logic              fss_n,
    output logic              mosi,
    input  logic              miso,
    output logic              busy,
    output logic              overrun
);
    logic              tx_full, tx_empty, tx_pop;
    logic [DATA_W-1:0] tx_head;
    logic              rx_full, rx_empty, rx_push;
    logic [DATA_W-1:0] rx_word;
    logic              ovr_d, ovr_q;

    spi_fm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_valid),
        .wdata (tx_data),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_fm_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .word_len (word_len),
        .clk_div  (clk_div),
        .tx_has   (!tx_empty),
        .tx_word  (tx_head),
        .tx_pop   (tx_pop),
        .miso     (miso),
        .sclk     (sclk),
        .fss_n    (fss_n),
        .mosi     (mosi),
        .busy     (busy),
        .rx_push  (rx_push),
        .rx_word  (rx_word)
    );

    spi_fm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .rdata (rx_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    always_comb begin
        ovr_d = ovr_q | (rx_push & rx_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    assign tx_ready = !tx_full;
    assign rx_valid = !rx_empty;
    assign overrun  = ovr_q;
    assign sclk_oe  = master_mode;

endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic sclk,
    input logic fss_n,
    input logic mosi,
    input logic busy,
    input logic overrun
);
    // R1
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk && fss_n && !mosi));

    // R1
    no_idle_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> busy);

    // R2
    start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fss_n) |-> $past(enable));

    // R4
    mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));

    // R6
    release_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fss_n) |-> (sclk && $past(sclk)));

    // R8
    busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !fss_n);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .sclk    (sclk),
    .fss_n   (fss_n),
    .mosi    (mosi),
    .busy    (busy),
    .overrun (overrun)
);

// File: tb/tb_spi_frame_master.sv
`timescale 1ns/1ps
module tb_spi_frame_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        master_mode = 1'b1;
    logic [3:0]  word_len = 4'd7;
    logic [7:0]  clk_div = 8'd4;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        rx_pop = 1'b0;
    logic        sclk, sclk_oe, fss_n, mosi, busy, overrun;
    logic        inv = 1'b0;
    logic        miso;

    assign miso = mosi ^ inv;

    always #10 clk = ~clk;

    spi_frame_master dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
        .word_len(word_len), .clk_div(clk_div), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_pop(rx_pop), .sclk(sclk), .sclk_oe(sclk_oe),
        .fss_n(fss_n), .mosi(mosi), .miso(miso), .busy(busy), .overrun(overrun)
    );

    int checks = 0;
    int fails  = 0;

    int w_first, w_last, w_end, w_rise, w_fall, w_perbad, w_busybad;
    logic [63:0] w_stream;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int n);
        return (32'd1 << n) - 32'd1;
    endfunction

    function automatic int bits_of(input int l);
        return (l < 3) ? 4 : l + 1;
    endfunction

    task automatic push_word(input logic [15:0] w);
        @(negedge clk);
        tx_data  = w;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic pop_word();
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    // observe one frame from frame-select fall to release
    task automatic watch(input int h);
        int guard;
        int t;
        logic prev;
        guard = 0;
        while (fss_n !== 1'b0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        w_first = -1; w_last = -1; w_rise = 0; w_fall = 0;
        w_perbad = 0; w_busybad = 0; w_stream = '0;
        prev = sclk;
        t = 0;
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            t++;
            if (sclk !== prev) begin
                if (sclk == 1'b0) begin
                    w_fall++;
                    if (w_fall == 1) w_first = t;
                    if (((t - h) % (2 * h)) != 0) w_perbad++;
                end else begin
                    w_rise++;
                    w_last = t;
                    w_stream = {w_stream[62:0], mosi};
                    if ((t % (2 * h)) != 0) w_perbad++;
                end
                prev = sclk;
            end
            if (busy !== !fss_n) w_busybad++;
            if (fss_n === 1'b1) break;
        end
        w_end = t;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] wl [5];
        wl[0] = 16'h3C5A; wl[1] = 16'hC3A5; wl[2] = 16'h0FF0; wl[3] = 16'h9669; wl[4] = 16'h7E81;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "sclk after reset", sclk, 1);
        chk("R1", "fss_n after reset", fss_n, 1);
        chk("R1", "mosi after reset", mosi, 0);
        chk("R1", "busy after reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "tx_ready empty queue", tx_ready, 1);
        chk("R9", "rx_valid empty queue", rx_valid, 0);
        chk("R10", "overrun after reset", overrun, 0);

        // R12 clock driver enable
        master_mode = 1'b0; #1;
        chk("R12", "sclk_oe slave", sclk_oe, 0);
        master_mode = 1'b1; #1;
        chk("R12", "sclk_oe master", sclk_oe, 1);

        // R2 enable low keeps the word queued
        enable = 1'b0; word_len = 4'd7; clk_div = 8'd4;
        push_word(16'h00A5);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (fss_n !== 1'b1 || busy !== 1'b0 || sclk !== 1'b1 || mosi !== 1'b0) bad++;
            end
            chk("R2", "idle while disabled", bad, 0);
        end
        chk("R2", "no rx while disabled", rx_valid, 0);
        @(negedge clk);
        enable = 1'b1;
        watch(2);
        chk("R2", "rises after enable", w_rise, 8);
        chk("R9", "rx_valid after word", rx_valid, 1);
        chk("R9", "rx word after enable", rx_data, 16'h00A5);
        pop_word();

        // R3 R4 R5 R6 R8 R9 sweep over divider and every length code
        foreach (wl[i]) begin end
        for (int di = 0; di < 4; di++) begin
            int dv;
            int h;
            dv = (di == 0) ? 0 : (di == 1) ? 3 : (di == 2) ? 4 : 6;
            h  = (dv / 2 < 1) ? 1 : dv / 2;
            for (int l = 0; l < 16; l++) begin
                int n;
                logic [15:0] w;
                logic [31:0] m;
                n = bits_of(l);
                m = mask_of(n);
                w = 16'hA5C3 ^ (16'(l) * 16'h1111) ^ 16'(dv);
                clk_div  = 8'(dv);
                word_len = 4'(l);
                inv      = l[0];
                push_word(w);
                watch(h);
                chk("R3", "first fall offset", w_first, h);
                chk("R5", "rising edge count", w_rise, n);
                chk("R5", "falling edge count", w_fall, n);
                chk("R4", "last capture time", w_last, 2 * n * h);
                chk("R4", "edge period errors", w_perbad, 0);
                chk("R6", "release delay", w_end - w_last, 2 * h);
                chk("R8", "busy mismatches", w_busybad, 0);
                chk("R5", "MSB-first stream", w_stream & 64'(m), 64'(w) & 64'(m));
                @(negedge clk);
                chk("R1", "sclk idle after frame", sclk, 1);
                chk("R1", "mosi idle after frame", mosi, 0);
                chk("R9", "rx_valid", rx_valid, 1);
                chk("R5", "rx word", rx_data, (32'(w) ^ (inv ? 32'hFFFF : 32'h0)) & m);
                pop_word();
            end
        end
        inv = 1'b0;

        // R7 back-to-back words keep the frame open
        enable = 1'b0; clk_div = 8'd4; word_len = 4'd7;
        for (int i = 0; i < 3; i++) push_word(wl[i]);
        @(negedge clk);
        enable = 1'b1;
        watch(2);
        chk("R7", "rises across three words", w_rise, 24);
        chk("R7", "period errors across words", w_perbad, 0);
        chk("R7", "frame length", w_end, 2 * 24 * 2 + 4);
        chk("R7", "first fall", w_first, 2);
        chk("R8", "busy mismatches b2b", w_busybad, 0);
        chk("R7", "stream", w_stream[23:0], {wl[0][7:0], wl[1][7:0], wl[2][7:0]});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9", "in-order rx", rx_data, wl[i][7:0]);
            pop_word();
        end
        @(negedge clk);
        chk("R9", "rx drained", rx_valid, 0);

        // R11 full transmit queue rejects pushes
        enable = 1'b0; word_len = 4'd3; clk_div = 8'd2;
        for (int i = 0; i < 4; i++) push_word(wl[i]);
        chk("R11", "tx_ready when full", tx_ready, 0);
        push_word(wl[4]);
        @(negedge clk);
        enable = 1'b1;
        watch(1);
        chk("R11", "only four words sent", w_rise, 16);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R11", "queued word", rx_data, wl[i][3:0]);
            pop_word();
        end
        @(negedge clk);
        chk("R11", "extra word dropped", rx_valid, 0);
        chk("R11", "tx_ready after drain", tx_ready, 1);

        // R10 overrun on full receive queue
        enable = 1'b0; word_len = 4'd15; clk_div = 8'd2;
        for (int i = 0; i < 4; i++) push_word(wl[i]);
        @(negedge clk);
        enable = 1'b1;
        watch(1);
        chk("R10", "no overrun at four", overrun, 0);
        push_word(wl[4]);
        watch(1);
        @(negedge clk);
        chk("R10", "overrun set", overrun, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R10", "kept word", rx_data, wl[i]);
            pop_word();
        end
        @(negedge clk);
        chk("R10", "fifth word discarded", rx_valid, 0);
        chk("R10", "overrun sticky", overrun, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule